// File: doc/BRIEF.md
# Row-Buffered Multi-Chip DRAM Controller

This block is a synchronous model of a word-wide memory built from several narrow DRAM chips, together with the controller that drives them. Each chip stores a grid of small cells. It is reached through one shared address field that carries a row index in one cycle and a column index in a later cycle. Opening a row copies the whole row into the chip's row buffer. Each column step then reads or writes one cell of that buffer. Closing the row writes the buffer back into the array.

The controller accepts word reads and writes on a valid/ready port. The flat address is split as {row, column}. Each word is spread across all chips at the same (row, column): chip k carries word bits 8k+7 down to 8k. After an access the row stays open, so a later request to the same row needs only a column step. A request to a different row first closes the open row and then opens the new one. A free-running timer schedules a refresh of one row per interval, taking the rows in turn. A refresh delays new requests and always leaves every row closed.

Top module: `sc_dram_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rd_valid is 0 and no row is open, so the first read takes the closed-row latency of R4.
- R2: A read at address {row, col} returns the 64-bit word last written there. Bits 8k+7..8k of the word are held by chip k at that row and column.
- R3: A read that hits the open row issues only a column step. rd_valid rises two cycles after the handshake cycle.
- R4: A read issued while no row is open issues a row step and then a column step. rd_valid rises three cycles after the handshake cycle.
- R5: A read to a row other than the open one closes that row, writing its buffer back, then opens the new row. rd_valid rises four cycles after the handshake cycle, and earlier writes to the closed row are kept.
- R6: Each read gives exactly one single-cycle rd_valid pulse, and rd_data is valid in that cycle. A write never raises rd_valid.
- R7: With no traffic, req_ready falls once every REFRESH_INTERVAL cycles. It stays low for 3 cycles when no row is open and for 4 cycles when a row is open.
- R8: A refresh preserves stored data and leaves no row open, so the next read takes the R4 latency.
- R9: A pending refresh is started within a bounded number of cycles, whatever the traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address {row[3:2], col[1:0]} |
| req_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 64 | Read data |

## Verification
The assertions check the command order on every cycle. A column step or a close only happens on an open row, and an open only happens on a closed row. A same-row hit goes straight to the column step. rd_valid follows each read column step by one cycle, and a refresh always ends with the rows closed. They also check that a pending refresh is never left waiting too long. The bench scenarios are what show the exact hit, closed-row and conflict latencies measured at the ports. They also show data integrity across write-back and refresh, and the idle refresh period and stall lengths.

// File: rtl/sc_dram_pkg.sv
package sc_dram_pkg;
  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE
  } dram_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_REF_CLOSE,
    ST_REF_ACT,
    ST_REF_PRE
  } ctrl_state_e;
endpackage

// File: rtl/sc_dram_chip.sv
module sc_dram_chip
  import sc_dram_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int CELL_W   = 8,
  localparam int ADDR_W  = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  dram_cmd_e         cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CELL_W-1:0] wdata,
  output logic [CELL_W-1:0] rdata
);
  localparam int ROWS = 1 << ROW_BITS;
  localparam int COLS = 1 << COL_BITS;

  logic [COLS-1:0][CELL_W-1:0] cells [ROWS];
  logic [COLS-1:0][CELL_W-1:0] rowbuf;
  logic                        open_q;
  logic [ROW_BITS-1:0]         open_row_q;
  logic [ROW_BITS-1:0]         row_idx;
  logic [COL_BITS-1:0]         col_idx;

  assign row_idx = addr[ROW_BITS-1:0];
  assign col_idx = addr[COL_BITS-1:0];

  // array: written only by a row close, read only by a row open
  always_ff @(posedge clk) begin
    if (cmd == CMD_PRE) cells[open_row_q] <= rowbuf;
  end

  always_ff @(posedge clk) begin
    if (cmd == CMD_ACT)     rowbuf          <= cells[row_idx];
    else if (cmd == CMD_WR) rowbuf[col_idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q     <= 1'b0;
      open_row_q <= '0;
      rdata      <= '0;
    end else begin
      case (cmd)
        CMD_ACT: begin
          open_q     <= 1'b1;
          open_row_q <= row_idx;
        end
        CMD_PRE: open_q <= 1'b0;
        CMD_RD:  rdata  <= rowbuf[col_idx];
        default: ;
      endcase
    end
  end

  p_col_on_open_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_RD || cmd == CMD_WR) |-> open_q);
  p_close_on_open_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE) |-> open_q);
  p_open_on_closed_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ACT) |-> !open_q);
endmodule

// File: rtl/sc_dram_refresh.sv
module sc_dram_refresh #(
  parameter int ROW_BITS  = 2,
  parameter int INTERVAL  = 64,
  parameter int AGE_LIMIT = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                done,
  output logic                pending,
  output logic [ROW_BITS-1:0] ref_row
);
  localparam int CNT_W = $clog2(INTERVAL);
  localparam int AGE_W = $clog2(AGE_LIMIT) + 1;

  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic [AGE_W-1:0] age;

  assign tick = (cnt == CNT_W'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
      ref_row <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (done) ref_row <= ref_row + 1'b1;
      if (tick)      pending <= 1'b1;
      else if (done) pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !pending) age <= '0;
    else                 age <= age + 1'b1;
  end

  p_refresh_served_r9: assert property (@(posedge clk) disable iff (rst)
    pending |-> (age < AGE_W'(AGE_LIMIT)));
endmodule

// File: rtl/sc_dram_ctrl.sv
module sc_dram_ctrl
  import sc_dram_pkg::*;
#(
  parameter int ROW_BITS         = 2,
  parameter int COL_BITS         = 2,
  parameter int CELL_W           = 8,
  parameter int NUM_CHIPS        = 8,
  parameter int REFRESH_INTERVAL = 64,
  localparam int ADDR_W          = ROW_BITS + COL_BITS,
  localparam int WORD_W          = NUM_CHIPS * CELL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  localparam int CA_W = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;

  ctrl_state_e         state, state_nx;
  logic [ROW_BITS-1:0] row_q, open_row_q, ref_row;
  logic [COL_BITS-1:0] col_q;
  logic                we_q, row_open_q;
  logic [WORD_W-1:0]   wdata_q;
  logic                ref_pending, ref_done;
  logic                accept, hit;
  logic [ROW_BITS-1:0] in_row;
  dram_cmd_e           cmd;
  logic [CA_W-1:0]     chip_addr;

  assign in_row    = req_addr[ADDR_W-1:COL_BITS];
  assign req_ready = (state == ST_IDLE) && !ref_pending;
  assign accept    = req_valid && req_ready;
  assign hit       = row_open_q && (in_row == open_row_q);
  assign ref_done  = (state == ST_REF_PRE);

  sc_dram_refresh #(
    .ROW_BITS (ROW_BITS),
    .INTERVAL (REFRESH_INTERVAL),
    .AGE_LIMIT(16)
  ) u_refresh (
    .clk    (clk),
    .rst    (rst),
    .done   (ref_done),
    .pending(ref_pending),
    .ref_row(ref_row)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: begin
        if (ref_pending)  state_nx = row_open_q ? ST_REF_CLOSE : ST_REF_ACT;
        else if (accept)  state_nx = hit ? ST_COL : (row_open_q ? ST_PRE : ST_ACT);
      end
      ST_PRE:       state_nx = ST_ACT;
      ST_ACT:       state_nx = ST_COL;
      ST_COL:       state_nx = ST_IDLE;
      ST_REF_CLOSE: state_nx = ST_REF_ACT;
      ST_REF_ACT:   state_nx = ST_REF_PRE;
      ST_REF_PRE:   state_nx = ST_IDLE;
      default:      state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      we_q       <= 1'b0;
      wdata_q    <= '0;
      row_open_q <= 1'b0;
      open_row_q <= '0;
      rd_valid   <= 1'b0;
    end else begin
      state    <= state_nx;
      rd_valid <= (state == ST_COL) && !we_q;
      if (accept) begin
        row_q   <= in_row;
        col_q   <= req_addr[COL_BITS-1:0];
        we_q    <= req_we;
        wdata_q <= req_wdata;
      end
      case (state)
        ST_ACT: begin
          row_open_q <= 1'b1;
          open_row_q <= row_q;
        end
        ST_PRE, ST_REF_CLOSE, ST_REF_PRE: row_open_q <= 1'b0;
        default: ;
      endcase
    end
  end

  always_comb begin
    cmd       = CMD_NOP;
    chip_addr = '0;
    case (state)
      ST_ACT: begin
        cmd                     = CMD_ACT;
        chip_addr[ROW_BITS-1:0] = row_q;
      end
      ST_REF_ACT: begin
        cmd                     = CMD_ACT;
        chip_addr[ROW_BITS-1:0] = ref_row;
      end
      ST_COL: begin
        cmd                     = we_q ? CMD_WR : CMD_RD;
        chip_addr[COL_BITS-1:0] = col_q;
      end
      ST_PRE, ST_REF_CLOSE, ST_REF_PRE: cmd = CMD_PRE;
      default: ;
    endcase
  end

  for (genvar k = 0; k < NUM_CHIPS; k++) begin : g_chip
    sc_dram_chip #(
      .ROW_BITS(ROW_BITS),
      .COL_BITS(COL_BITS),
      .CELL_W  (CELL_W)
    ) u_chip (
      .clk  (clk),
      .rst  (rst),
      .cmd  (cmd),
      .addr (chip_addr),
      .wdata(wdata_q[k*CELL_W +: CELL_W]),
      .rdata(rd_data[k*CELL_W +: CELL_W])
    );
  end

  p_rdvalid_follows_read_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COL && !we_q) |=> rd_valid);
  p_rdvalid_only_after_read_r6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(state == ST_COL && !we_q));
  p_hit_skips_open_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && hit) |=> (state == ST_COL));
  p_refresh_closes_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REF_PRE) |=> !row_open_q);
  p_stall_in_refresh_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REF_ACT || state == ST_REF_PRE || state == ST_REF_CLOSE) |-> !req_ready);
endmodule

// File: tb/tb_sc_dram_ctrl.sv
`timescale 1ns/1ps
module tb_sc_dram_ctrl;
  localparam int INTERVAL = 64;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_we, rd_valid;
  logic [3:0]  req_addr;
  logic [63:0] req_wdata, rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [63:0] model [16];

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  sc_dram_ctrl #(.REFRESH_INTERVAL(INTERVAL)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic handshake(input logic we, input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [3:0] a, input logic [63:0] d);
    bit seen = 0;
    handshake(1'b1, a, d);
    model[a] = d;
    for (int i = 0; i < 4; i++) begin
      if (rd_valid) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R6", "rd_valid during write", 64'(seen), 64'd0);
  endtask

  task automatic do_read(input logic [3:0] a, output logic [63:0] d, output int lat);
    handshake(1'b0, a, 64'd0);
    lat = 1;
    while (!rd_valid) begin @(negedge clk); lat++; end
    d = rd_data;
    @(negedge clk);
    chk(!rd_valid, "R6", "rd_valid single pulse", 64'(rd_valid), 64'd0);
  endtask

  task automatic read_chk(input logic [3:0] a, input int exp_lat, input string lreq);
    logic [63:0] d; int lat;
    do_read(a, d, lat);
    chk(d == model[a], "R2", "read data", d, model[a]);
    if (exp_lat > 0) chk(lat == exp_lat, lreq, "read latency", 64'(lat), 64'(exp_lat));
  endtask

  task automatic wait_refresh_gap(output int fall_cyc, output int len);
    while (req_ready) @(negedge clk);
    fall_cyc = cyc; len = 0;
    while (!req_ready) begin @(negedge clk); len++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t1, t2, g1, g2, lat;
    logic [63:0] d;
    logic [3:0] a;
    int unsigned seed;
    seed = $urandom(32'd2024);
    rst = 1'b1; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", 64'(rd_valid), 64'd0);
    do_read(4'd0, d, lat);
    chk(lat == 3, "R1", "first read opens a row", 64'(lat), 64'd3);

    for (int i = 0; i < 16; i++) do_write(4'(i), {32'hC0DE0000 + 32'(i), $urandom});

    // directed latencies right after a refresh, before the next one
    wait_refresh_gap(t1, g1);
    read_chk(4'd5, 3, "R4");
    read_chk(4'd6, 2, "R3");
    do_write(4'd7, 64'h0123_4567_89AB_CDEF);
    read_chk(4'd7, 2, "R3");
    read_chk(4'd9, 4, "R5");
    read_chk(4'd7, 4, "R5");
    read_chk(4'd6, 2, "R3");

    // row 1 is open: next idle refresh stalls 4, the one after stalls 3
    wait_refresh_gap(t1, g1);
    chk(g1 == 4, "R7", "stall with open row", 64'(g1), 64'd4);
    wait_refresh_gap(t2, g2);
    chk(g2 == 3, "R7", "stall with closed row", 64'(g2), 64'd3);
    chk(t2 - t1 == INTERVAL, "R7", "refresh period", 64'(t2 - t1), 64'(INTERVAL));
    read_chk(4'd6, 3, "R8");
    for (int i = 0; i < 16; i++) read_chk(4'(i), 0, "R8");

    // constrained random traffic, biased toward row hits
    a = 4'd0;
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 3 != 0) a = {a[3:2], 2'($urandom)};
      else                   a = 4'($urandom);
      if ($urandom % 2 == 0) do_write(a, {$urandom, $urandom});
      else                   read_chk(a, 0, "R2");
    end
    for (int i = 0; i < 16; i++) read_chk(4'(i), 0, "R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule